// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

The block gathers level-sensitive interrupt lines and drives two processor request outputs. The first is a normal request (`irq_o`) and the second is a fast request (`fiq_o`). Every input line is registered before it is used. The registered lines are organised into banks. Each bank has a raw vector and two enable vectors, one for the normal request and one for the fast request. A status vector is the raw vector ANDed with the matching enable.

Direct sources feed the main bank. Two further kinds of bank sit in front of it:

- The error bank, a single bank for error lines.
- The thread banks, one per thread group.

Each of these front banks reduces its two status vectors to two summary bits, and those bits become raw bits of the main bank. Error and thread lines therefore pass through two enable levels, while direct lines pass through one.

Software reaches every bank over a simple register bus. The bus has one or more write ports and a single read port, and read data is registered. Enable bits never take a written value directly. They are changed only through set and clear addresses, and the set address also reads back the enable value. When several write ports act in the same cycle, they are applied in port order, so the highest-numbered port is the last write.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable register and the read data register are cleared. Both request outputs are therefore low after reset.
- R2: Input lines are captured on each clock edge and appear in raw status one cycle later, never combinationally. Main raw bit layout: bits [N_DIRECT-1:0] are the direct lines. Bit N_DIRECT is the error-bank normal summary and bit N_DIRECT+1 is the error-bank fast summary. Bits N_DIRECT+2+2g and N_DIRECT+3+2g are the normal and fast summaries of thread group g.
- R3: In every bank, normal status equals raw AND normal enable, and fast status equals raw AND fast enable.
- R4: `irq_o` is high exactly when main normal status is nonzero. `fiq_o` is high exactly when main fast status is nonzero.
- R5: A bank summary bit is set exactly when that bank's matching status is nonzero. An error or thread line reaches an output only if it is enabled in its own bank and its summary bit is enabled in the main bank.
- R6: Writing to a set address ORs the written 1s into the enable. Bits written as 0 and bits above the bank width leave the enable unchanged.
- R7: Writing to a clear address clears the enable bits written as 1 and leaves the others unchanged.
- R8: Bank b occupies word addresses 8b to 8b+7, with bank 0 the main bank, bank 1 the error bank, and bank 2+g thread group g. The offsets are:
  - 0: raw
  - 1: normal status
  - 2: fast status
  - 3: normal enable on read, normal set on write
  - 4: normal clear
  - 5: fast enable on read, fast set on write
  - 6: fast clear

  Read data is registered and shows the addressed value as it stood before the clock edge.
- R9: Writes to raw, status, offset 7 or unmapped banks change nothing. Reads of clear addresses, offset 7 or unmapped banks return 0.
- R10: Writes from several ports in one cycle are applied in ascending port order per enable bit, so the highest-numbered port's set or clear of a bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_irq_i | input | N_DIRECT | Direct interrupt lines |
| err_irq_i | input | N_ERR | Error interrupt lines |
| thr_irq_i | input | N_THR_GRP*THR_W | Thread interrupt lines, group g at [g*THR_W +: THR_W] |
| csr_wr_en_i | input | NWP | Write strobe per port |
| csr_wr_addr_i | input | NWP*AW | Word write address per port |
| csr_wr_data_i | input | NWP*32 | Write data per port |
| csr_rd_addr_i | input | AW | Word read address |
| csr_rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with four direct lines, four error lines, two thread groups of four lines, two write ports and an 8-bit address. Two write ports make same-cycle set and clear collisions on one enable bit reachable, so the port-order rule can be checked. Two thread groups put a thread bank above the error bank, so the bank stride and the summary bit placement for group 1 are tested. Addresses above bank 3 exercise the unmapped space.

// File: rtl/icx_pkg.sv
package icx_pkg;

  localparam int unsigned CSR_DW = 32;
  localparam int unsigned BLK_SH = 3;

  localparam logic [2:0] OFF_RAW   = 3'd0;
  localparam logic [2:0] OFF_ISTAT = 3'd1;
  localparam logic [2:0] OFF_FSTAT = 3'd2;
  localparam logic [2:0] OFF_IEN   = 3'd3;
  localparam logic [2:0] OFF_ICLR  = 3'd4;
  localparam logic [2:0] OFF_FEN   = 3'd5;
  localparam logic [2:0] OFF_FCLR  = 3'd6;

  // one write port's effect on one bank's enables
  typedef struct packed {
    logic iset;
    logic iclr;
    logic fset;
    logic fclr;
  } en_op_t;

  function automatic en_op_t decode_op(input logic hit, input logic [2:0] off);
    en_op_t op;
    op.iset = hit && (off == OFF_IEN);
    op.iclr = hit && (off == OFF_ICLR);
    op.fset = hit && (off == OFF_FEN);
    op.fclr = hit && (off == OFF_FCLR);
    return op;
  endfunction

  function automatic logic [CSR_DW-1:0] rd_select(
    input logic [2:0]        off,
    input logic [CSR_DW-1:0] raw,
    input logic [CSR_DW-1:0] istat,
    input logic [CSR_DW-1:0] fstat,
    input logic [CSR_DW-1:0] ien,
    input logic [CSR_DW-1:0] fen
  );
    logic [CSR_DW-1:0] v;
    case (off)
      OFF_RAW:   v = raw;
      OFF_ISTAT: v = istat;
      OFF_FSTAT: v = fstat;
      OFF_IEN:   v = ien;
      OFF_FEN:   v = fen;
      default:   v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/icx_wr_decode.sv
module icx_wr_decode
  import icx_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned NB  = 4,
  parameter int unsigned NWP = 2
) (
  input  logic [NWP-1:0]             wr_en_i,
  input  logic [NWP*AW-1:0]          wr_addr_i,
  output en_op_t [NB-1:0][NWP-1:0]   ops_o,
  output logic [NB-1:0]              touch_o
);

  localparam int unsigned BW = AW - BLK_SH;

  for (genvar p = 0; p < NWP; p++) begin : g_port
    logic [BW-1:0] blk;
    logic [2:0]    off;
    assign blk = wr_addr_i[p*AW+BLK_SH +: BW];
    assign off = wr_addr_i[p*AW +: BLK_SH];
    for (genvar b = 0; b < NB; b++) begin : g_bank
      assign ops_o[b][p] = decode_op(wr_en_i[p] && (blk == BW'(b)), off);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_touch
    assign touch_o[b] = |ops_o[b];
  end

endmodule

// File: rtl/icx_mask_bank.sv
module icx_mask_bank
  import icx_pkg::*;
#(
  parameter int unsigned W   = 4,
  parameter int unsigned NWP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           raw_i,
  input  en_op_t [NWP-1:0]       ops_i,
  input  logic [NWP-1:0][W-1:0]  wdata_i,
  output logic [W-1:0]           ien_o,
  output logic [W-1:0]           fen_o,
  output logic [W-1:0]           istat_o,
  output logic [W-1:0]           fstat_o,
  output logic                   irq_any_o,
  output logic                   fiq_any_o
);

  logic [W-1:0] ien_q, fen_q, ien_n, fen_n;

  function automatic logic [W-1:0] step_en(
    input logic [W-1:0] cur,
    input logic [W-1:0] d,
    input logic         set,
    input logic         clr
  );
    logic [W-1:0] r;
    r = cur;
    if (set) r = r | d;
    if (clr) r = r & ~d;
    return r;
  endfunction

  function automatic logic [W-1:0] apply_mask(input logic [W-1:0] raw, input logic [W-1:0] en);
    return raw & en;
  endfunction

  // ports applied in ascending order: a later port overrides an earlier one
  always_comb begin
    ien_n = ien_q;
    fen_n = fen_q;
    for (int p = 0; p < NWP; p++) begin
      ien_n = step_en(ien_n, wdata_i[p], ops_i[p].iset, ops_i[p].iclr);
      fen_n = step_en(fen_n, wdata_i[p], ops_i[p].fset, ops_i[p].fclr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      fen_q <= '0;
    end else begin
      ien_q <= ien_n;
      fen_q <= fen_n;
    end
  end

  assign ien_o     = ien_q;
  assign fen_o     = fen_q;
  assign istat_o   = apply_mask(raw_i, ien_q);
  assign fstat_o   = apply_mask(raw_i, fen_q);
  assign irq_any_o = |istat_o;
  assign fiq_any_o = |fstat_o;

endmodule

// File: rtl/icx_rd_mux.sv
module icx_rd_mux
  import icx_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned NB = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               rd_addr_i,
  input  logic [NB-1:0][CSR_DW-1:0]   raw_i,
  input  logic [NB-1:0][CSR_DW-1:0]   istat_i,
  input  logic [NB-1:0][CSR_DW-1:0]   fstat_i,
  input  logic [NB-1:0][CSR_DW-1:0]   ien_i,
  input  logic [NB-1:0][CSR_DW-1:0]   fen_i,
  output logic [CSR_DW-1:0]           rd_data_o
);

  localparam int unsigned BW = AW - BLK_SH;

  logic [BW-1:0]     blk;
  logic [2:0]        off;
  logic [CSR_DW-1:0] sel;
  logic [CSR_DW-1:0] rd_q;

  assign blk = rd_addr_i[AW-1:BLK_SH];
  assign off = rd_addr_i[BLK_SH-1:0];

  always_comb begin
    sel = '0;
    for (int b = 0; b < NB; b++) begin
      if (blk == BW'(b)) begin
        sel = rd_select(off, raw_i[b], istat_i[b], fstat_i[b], ien_i[b], fen_i[b]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= sel;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import icx_pkg::*;
#(
  parameter int unsigned N_DIRECT  = 4,
  parameter int unsigned N_ERR     = 4,
  parameter int unsigned N_THR_GRP = 2,
  parameter int unsigned THR_W     = 4,
  parameter int unsigned NWP       = 2,
  parameter int unsigned AW        = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_DIRECT-1:0]         direct_irq_i,
  input  logic [N_ERR-1:0]            err_irq_i,
  input  logic [N_THR_GRP*THR_W-1:0]  thr_irq_i,
  input  logic [NWP-1:0]              csr_wr_en_i,
  input  logic [NWP*AW-1:0]           csr_wr_addr_i,
  input  logic [NWP*32-1:0]           csr_wr_data_i,
  input  logic [AW-1:0]               csr_rd_addr_i,
  output logic [31:0]                 csr_rd_data_o,
  output logic                        irq_o,
  output logic                        fiq_o
);

  localparam int unsigned NB     = 2 + N_THR_GRP;
  localparam int unsigned RAW_W  = N_DIRECT + 2 + 2*N_THR_GRP;
  localparam int unsigned ERR_IB = N_DIRECT;
  localparam int unsigned ERR_FB = N_DIRECT + 1;

  // registered input lines
  logic [N_DIRECT-1:0]        direct_q;
  logic [N_ERR-1:0]           err_q;
  logic [N_THR_GRP*THR_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      direct_q <= '0;
      err_q    <= '0;
      thr_q    <= '0;
    end else begin
      direct_q <= direct_irq_i;
      err_q    <= err_irq_i;
      thr_q    <= thr_irq_i;
    end
  end

  // write decode
  en_op_t [NB-1:0][NWP-1:0] ops;
  logic   [NB-1:0]          touch;

  icx_wr_decode #(.AW(AW), .NB(NB), .NWP(NWP)) u_dec (
    .wr_en_i   (csr_wr_en_i),
    .wr_addr_i (csr_wr_addr_i),
    .ops_o     (ops),
    .touch_o   (touch)
  );

  // read-side collections, zero-extended to the bus width
  logic [NB-1:0][CSR_DW-1:0] raw_a, istat_a, fstat_a, ien_a, fen_a;

  // error bank
  logic [NWP-1:0][N_ERR-1:0] err_wd;
  logic [N_ERR-1:0] err_ien, err_fen, err_istat, err_fstat;
  logic err_irq_any, err_fiq_any;

  for (genvar p = 0; p < NWP; p++) begin : g_err_wd
    assign err_wd[p] = csr_wr_data_i[p*32 +: N_ERR];
  end

  icx_mask_bank #(.W(N_ERR), .NWP(NWP)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (err_q),
    .ops_i     (ops[1]),
    .wdata_i   (err_wd),
    .ien_o     (err_ien),
    .fen_o     (err_fen),
    .istat_o   (err_istat),
    .fstat_o   (err_fstat),
    .irq_any_o (err_irq_any),
    .fiq_any_o (err_fiq_any)
  );

  assign raw_a[1]   = 32'(err_q);
  assign istat_a[1] = 32'(err_istat);
  assign fstat_a[1] = 32'(err_fstat);
  assign ien_a[1]   = 32'(err_ien);
  assign fen_a[1]   = 32'(err_fen);

  // thread banks
  logic [N_THR_GRP-1:0] thr_irq_any, thr_fiq_any;

  for (genvar g = 0; g < N_THR_GRP; g++) begin : g_thr
    logic [NWP-1:0][THR_W-1:0] wd;
    logic [THR_W-1:0] ien, fen, istat, fstat;
    for (genvar p = 0; p < NWP; p++) begin : g_wd
      assign wd[p] = csr_wr_data_i[p*32 +: THR_W];
    end
    icx_mask_bank #(.W(THR_W), .NWP(NWP)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (thr_q[g*THR_W +: THR_W]),
      .ops_i     (ops[2+g]),
      .wdata_i   (wd),
      .ien_o     (ien),
      .fen_o     (fen),
      .istat_o   (istat),
      .fstat_o   (fstat),
      .irq_any_o (thr_irq_any[g]),
      .fiq_any_o (thr_fiq_any[g])
    );
    assign raw_a[2+g]   = 32'(thr_q[g*THR_W +: THR_W]);
    assign istat_a[2+g] = 32'(istat);
    assign fstat_a[2+g] = 32'(fstat);
    assign ien_a[2+g]   = 32'(ien);
    assign fen_a[2+g]   = 32'(fen);
  end

  // main raw vector: direct lines plus folded bank summaries
  logic [RAW_W-1:0] main_raw;
  assign main_raw[N_DIRECT-1:0] = direct_q;
  assign main_raw[ERR_IB]       = err_irq_any;
  assign main_raw[ERR_FB]       = err_fiq_any;
  for (genvar g = 0; g < N_THR_GRP; g++) begin : g_fold
    assign main_raw[N_DIRECT+2+2*g] = thr_irq_any[g];
    assign main_raw[N_DIRECT+3+2*g] = thr_fiq_any[g];
  end

  // main bank
  logic [NWP-1:0][RAW_W-1:0] main_wd;
  logic [RAW_W-1:0] main_ien, main_fen, main_istat, main_fstat;
  logic main_irq_any, main_fiq_any;
  logic main_touch;

  for (genvar p = 0; p < NWP; p++) begin : g_main_wd
    assign main_wd[p] = csr_wr_data_i[p*32 +: RAW_W];
  end

  icx_mask_bank #(.W(RAW_W), .NWP(NWP)) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (main_raw),
    .ops_i     (ops[0]),
    .wdata_i   (main_wd),
    .ien_o     (main_ien),
    .fen_o     (main_fen),
    .istat_o   (main_istat),
    .fstat_o   (main_fstat),
    .irq_any_o (main_irq_any),
    .fiq_any_o (main_fiq_any)
  );

  assign main_touch = touch[0];
  assign raw_a[0]   = 32'(main_raw);
  assign istat_a[0] = 32'(main_istat);
  assign fstat_a[0] = 32'(main_fstat);
  assign ien_a[0]   = 32'(main_ien);
  assign fen_a[0]   = 32'(main_fen);

  icx_rd_mux #(.AW(AW), .NB(NB)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_i (csr_rd_addr_i),
    .raw_i     (raw_a),
    .istat_i   (istat_a),
    .fstat_i   (fstat_a),
    .ien_i     (ien_a),
    .fen_i     (fen_a),
    .rd_data_o (csr_rd_data_o)
  );

  assign irq_o = main_irq_any;
  assign fiq_o = main_fiq_any;

endmodule

// File: rtl/icx_ctrl_chk.sv
module icx_ctrl_chk #(
  parameter int unsigned ND = 4,
  parameter int unsigned RW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [ND-1:0] direct_i,
  input logic          irq_i,
  input logic          fiq_i,
  input logic [RW-1:0] main_raw_i,
  input logic [RW-1:0] main_ien_i,
  input logic [RW-1:0] main_fen_i,
  input logic          err_irq_any_i,
  input logic          err_fiq_any_i,
  input logic          main_touch_i
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (main_ien_i == '0) && (main_fen_i == '0) && !irq_i && !fiq_i);

  assert_raw_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (main_raw_i[ND-1:0] == $past(direct_i)));

  assert_no_irq_unenabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ien_i == '0) |-> !irq_i);

  assert_no_fiq_unenabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_fen_i == '0) |-> !fiq_i);

  assert_err_reaches_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq_any_i && main_ien_i[ND]) |-> irq_i);

  assert_err_reaches_fiq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fiq_any_i && main_fen_i[ND+1]) |-> fiq_i);

  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !main_touch_i |=> $stable(main_ien_i) && $stable(main_fen_i));

endmodule

bind irq_fiq_ctrl icx_ctrl_chk #(.ND(N_DIRECT), .RW(RAW_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .direct_i      (direct_irq_i),
  .irq_i         (irq_o),
  .fiq_i         (fiq_o),
  .main_raw_i    (main_raw),
  .main_ien_i    (main_ien),
  .main_fen_i    (main_fen),
  .err_irq_any_i (err_irq_any),
  .err_fiq_any_i (err_fiq_any),
  .main_touch_i  (main_touch)
);

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb;

  localparam int ND  = 4;
  localparam int NE  = 4;
  localparam int NG  = 2;
  localparam int TW  = 4;
  localparam int NWP = 2;
  localparam int AW  = 8;
  localparam int NB  = 2 + NG;
  localparam int RW  = ND + 2 + 2*NG;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [ND-1:0]     dir_i;
  logic [NE-1:0]     err_i;
  logic [NG*TW-1:0]  thr_i;
  logic [NWP-1:0]    we;
  logic [NWP*AW-1:0] wa;
  logic [NWP*32-1:0] wd;
  logic [AW-1:0]     ra;
  logic [31:0]       rd;
  logic              irq, fiq;

  irq_fiq_ctrl #(.N_DIRECT(ND), .N_ERR(NE), .N_THR_GRP(NG), .THR_W(TW), .NWP(NWP), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .direct_irq_i(dir_i), .err_irq_i(err_i), .thr_irq_i(thr_i),
    .csr_wr_en_i(we), .csr_wr_addr_i(wa), .csr_wr_data_i(wd), .csr_rd_addr_i(ra),
    .csr_rd_data_o(rd), .irq_o(irq), .fiq_o(fiq)
  );

  int checks = 0;
  int errors = 0;

  // model state
  logic [ND-1:0]    m_dir;
  logic [NE-1:0]    m_err;
  logic [NG*TW-1:0] m_thr;
  logic [31:0]      m_ien [NB];
  logic [31:0]      m_fen [NB];

  // stimulus
  logic [ND-1:0]    s_dir;
  logic [NE-1:0]    s_err;
  logic [NG*TW-1:0] s_thr;
  logic [NWP-1:0]   s_we;
  logic [AW-1:0]    s_wa [NWP];
  logic [31:0]      s_wd [NWP];
  logic [AW-1:0]    s_ra;

  function automatic logic [31:0] wmask(input int b);
    int w;
    w = (b == 0) ? RW : (b == 1) ? NE : TW;
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] bank_raw(input int b);
    logic [31:0] r;
    if (b == 1) return 32'(m_err);
    if (b >= 2) return 32'(m_thr[(b-2)*TW +: TW]);
    r = 32'(m_dir);
    r[ND]   = |(32'(m_err) & m_ien[1]);
    r[ND+1] = |(32'(m_err) & m_fen[1]);
    for (int g = 0; g < NG; g++) begin
      r[ND+2+2*g] = |(32'(m_thr[g*TW +: TW]) & m_ien[2+g]);
      r[ND+3+2*g] = |(32'(m_thr[g*TW +: TW]) & m_fen[2+g]);
    end
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int b;
    b = int'(a >> 3);
    if (b >= NB) return 32'd0;
    case (a[2:0])
      3'd0: return bank_raw(b);
      3'd1: return bank_raw(b) & m_ien[b];
      3'd2: return bank_raw(b) & m_fen[b];
      3'd3: return m_ien[b];
      3'd5: return m_fen[b];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge();
    for (int p = 0; p < NWP; p++) begin
      if (s_we[p]) begin
        int b;
        logic [31:0] d;
        b = int'(s_wa[p] >> 3);
        if (b < NB) begin
          d = s_wd[p] & wmask(b);
          case (s_wa[p][2:0])
            3'd3: m_ien[b] = m_ien[b] | d;
            3'd4: m_ien[b] = m_ien[b] & ~d;
            3'd5: m_fen[b] = m_fen[b] | d;
            3'd6: m_fen[b] = m_fen[b] & ~d;
            default: ;
          endcase
        end
      end
    end
    m_dir = s_dir;
    m_err = s_err;
    m_thr = s_thr;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, sample at the following negedge
  task automatic cycle(input string tag);
    logic [31:0] exp_rd;
    exp_rd = model_read(s_ra);
    dir_i = s_dir; err_i = s_err; thr_i = s_thr;
    we = s_we; ra = s_ra;
    for (int p = 0; p < NWP; p++) begin
      wa[p*AW +: AW] = s_wa[p];
      wd[p*32 +: 32] = s_wd[p];
    end
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check("R4 irq", 32'(irq), 32'(|(bank_raw(0) & m_ien[0])));
    check("R4 fiq", 32'(fiq), 32'(|(bank_raw(0) & m_fen[0])));
    check(tag, rd, exp_rd);
    s_we = '0;
  endtask

  task automatic wr(input int p, input logic [AW-1:0] a, input logic [31:0] d);
    s_we[p] = 1'b1; s_wa[p] = a; s_wd[p] = d;
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    s_ra = a;
    cycle(tag);
    check(tag, rd, exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    dir_i = '0; err_i = '0; thr_i = '0; we = '0; wa = '0; wd = '0; ra = '0;
    s_dir = '0; s_err = '0; s_thr = '0; s_we = '0; s_ra = '0;
    m_dir = '0; m_err = '0; m_thr = '0;
    for (int b = 0; b < NB; b++) begin m_ien[b] = '0; m_fen[b] = '0; end
    for (int p = 0; p < NWP; p++) begin s_wa[p] = '0; s_wd[p] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 fiq", 32'(fiq), 32'd0);
    check("R1 rd", rd, 32'd0);
    rst_n = 1'b1;

    rd_expect(8'h03, 32'd0, "R1 ien");
    rd_expect(8'h00, 32'd0, "R1 raw");

    // R2: one-cycle capture latency
    s_dir = 4'b0101; s_ra = 8'h00;
    cycle("R2");
    check("R2 latency", rd, 32'd0);
    rd_expect(8'h00, 32'h5, "R2 raw");

    // R6 set
    wr(0, 8'h03, 32'h3); cycle("R6");
    rd_expect(8'h03, 32'h3, "R6");
    check("R4 irq on", 32'(irq), 32'd1);
    wr(0, 8'h03, 32'h4); cycle("R6");
    rd_expect(8'h03, 32'h7, "R6 zeros kept");

    // R7 clear
    wr(0, 8'h04, 32'h5); cycle("R7");
    rd_expect(8'h03, 32'h2, "R7");
    check("R4 irq off", 32'(irq), 32'd0);
    rd_expect(8'h01, 32'h0, "R3 istat");
    wr(1, 8'h03, 32'h4); cycle("R6");
    rd_expect(8'h01, 32'h4, "R3 istat");

    // R9 ignored writes and zero reads
    wr(0, 8'h00, 32'hFFFF_FFFF); wr(1, 8'h01, 32'hFFFF_FFFF); cycle("R9");
    wr(0, 8'h07, 32'hFFFF_FFFF); wr(1, 8'hFB, 32'hFFFF_FFFF); cycle("R9");
    rd_expect(8'h03, 32'h6, "R9 ien");
    rd_expect(8'h05, 32'h0, "R9 fen");
    rd_expect(8'h04, 32'h0, "R9 clr read");
    rd_expect(8'hFB, 32'h0, "R9 unmapped");

    // R10 same-cycle ordering
    wr(0, 8'h05, 32'h1); wr(1, 8'h06, 32'h1); cycle("R10");
    rd_expect(8'h05, 32'h0, "R10 clear last");
    wr(0, 8'h06, 32'h1); wr(1, 8'h05, 32'h1); cycle("R10");
    rd_expect(8'h05, 32'h1, "R10 set last");
    check("R4 fiq on", 32'(fiq), 32'd1);
    wr(0, 8'h03, 32'h1); wr(1, 8'h03, 32'h8); cycle("R10");
    rd_expect(8'h03, 32'hF, "R10 both set");

    // R5 two-level error and thread paths
    s_dir = '0;
    wr(0, 8'h04, 32'hFFFF_FFFF); wr(1, 8'h06, 32'hFFFF_FFFF); cycle("R7");
    s_err = 4'b0100; wr(0, 8'h0B, 32'h4); cycle("R5");
    rd_expect(8'h09, 32'h4, "R5 err istat");
    check("R5 gated by main", 32'(irq), 32'd0);
    rd_expect(8'h00, 32'h10, "R5 fold");
    wr(0, 8'h03, 32'h10); cycle("R5");
    check("R5 err irq", 32'(irq), 32'd1);
    s_thr = 8'b0010_0000; wr(0, 8'h1D, 32'h2); wr(1, 8'h05, 32'h200); cycle("R5");
    check("R5 thr fiq", 32'(fiq), 32'd1);
    wr(0, 8'h1E, 32'h2); cycle("R5");
    check("R5 thr gated", 32'(fiq), 32'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      s_dir = ND'($urandom);
      s_err = NE'($urandom);
      s_thr = (NG*TW)'($urandom);
      for (int p = 0; p < NWP; p++) begin
        s_we[p] = ($urandom % 3) == 0;
        s_wa[p] = {5'($urandom % (NB + 1)), 3'($urandom)};
        s_wd[p] = $urandom;
      end
      s_ra = (($urandom % 8) == 0) ? AW'($urandom) : {5'($urandom % NB), 3'($urandom)};
      cycle("R3 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule